// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry-Extended Rotate

This block conditions the second operand of an arithmetic/logic unit before it reaches the adder or logic array. It is purely combinational. It takes a 32-bit word, a 5-bit distance, a 3-bit operation code and the processor's current carry flag. In the same evaluation it returns the conditioned word and the bit that should become the carry flag when the instruction updates flags.

Five operations are provided:

- a left shift with zero fill;
- a right shift with zero fill;
- a right shift that replicates the sign bit;
- a plain right rotation;
- a one-place right rotation through the carry flag, which treats the carry as a thirty-third bit sitting above the word.

A zero distance, and any operation code that is not assigned, leave the word untouched. In those cases the incoming carry is forwarded unchanged.

Top module: `operand_shifter`

## Requirements
- R1: With op code 0 (left shift) and distance n from 1 to 31, the result is the input moved up n places with zeros entering at bit 0, and the carry out is input bit 32-n.
- R2: With op code 1 (logical right shift) and n from 1 to 31, the result is the input moved down n places with zeros entering at bit 31, and the carry out is input bit n-1.
- R3: With op code 2 (arithmetic right shift) and n from 1 to 31, the vacated upper positions are filled with copies of input bit 31, and the carry out is input bit n-1.
- R4: With op code 3 (rotate right) and n from 1 to 31, result bit i equals input bit (i+n) mod 32, and the carry out is input bit n-1.
- R5: With op code 4 (carry-extended rotate), the result is the carry flag in bit 31 followed by input bits 31 down to 1, and the carry out is input bit 0. The distance input has no effect, including a distance of zero.
- R6: With op codes 0 to 3 and a distance of zero, the result equals the input and the carry out equals the carry flag.
- R7: Op codes 5, 6 and 7 pass the input through unchanged with the carry out equal to the carry flag, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_val | input | 32 | Word to be conditioned |
| shamt | input | 5 | Shift or rotate distance |
| kind | input | 3 | Operation code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 carry rotate) |
| carry_in | input | 1 | Current carry flag |
| res | output | 32 | Conditioned word |
| carry_out | output | 1 | Carry produced by the operation |

## Verification
Two rules meet in a single evaluation when the carry-extended rotate is selected with a distance of zero. The zero-distance pass-through applies to ordinary shifts, while the rotate must ignore the distance. The sweep drives that combination with both carry values and with words whose bit 0 and bit 31 differ. It judges the result as a one-place rotate through the carry, never as a pass-through. The data result and the carry out are also produced together, so every vector compares both against bit-by-bit models of the shift.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        K_LSL = 3'd0,
        K_LSR = 3'd1,
        K_ASR = 3'd2,
        K_ROR = 3'd3,
        K_RRX = 3'd4,
        K_RS5 = 3'd5,
        K_RS6 = 3'd6,
        K_RS7 = 3'd7
    } shf_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              carry;
    } shf_result_t;

    function automatic shf_result_t mk_pass(input logic [DATA_W-1:0] v,
                                            input logic c);
        shf_result_t r;
        r.data  = v;
        r.carry = c;
        return r;
    endfunction

endpackage

// File: rtl/shf_left_unit.sv
module shf_left_unit #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          co
);
    logic [AW-1:0] out_idx;

    always_comb begin
        res     = val << amt;
        // W is a power of two, so W - amt wraps cleanly into AW bits
        out_idx = AW'(W) - amt;
        co      = (amt == '0) ? 1'b0 : val[out_idx];
    end
endmodule

// File: rtl/shf_right_unit.sv
module shf_right_unit #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    input  logic          rotate,
    output logic [W-1:0]  res,
    output logic          co
);
    logic [W-1:0]   upper;
    logic [2*W-1:0] wide;
    logic [AW-1:0]  out_idx;

    always_comb begin
        if (rotate)     upper = val;
        else if (arith) upper = {W{val[W-1]}};
        else            upper = '0;
        wide    = {upper, val} >> amt;
        res     = wide[W-1:0];
        out_idx = amt - AW'(1);
        co      = (amt == '0) ? 1'b0 : val[out_idx];
    end
endmodule

// File: rtl/shf_rrx_unit.sv
module shf_rrx_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         co
);
    always_comb begin
        res = {cin, val[W-1:1]};
        co  = val[0];
    end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import shf_pkg::*;
(
    input  logic [DATA_W-1:0] op_val,
    input  logic [AMT_W-1:0]  shamt,
    input  logic [2:0]        kind,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              carry_out
);
    shf_kind_e   k;
    shf_result_t left_r, right_r, rrx_r, sel_r;
    logic        amt_zero;

    assign k = shf_kind_e'(kind);

    shf_left_unit #(.W(DATA_W), .AW(AMT_W)) u_left (
        .val(op_val), .amt(shamt), .res(left_r.data), .co(left_r.carry)
    );

    shf_right_unit #(.W(DATA_W), .AW(AMT_W)) u_right (
        .val(op_val), .amt(shamt),
        .arith(k == K_ASR), .rotate(k == K_ROR),
        .res(right_r.data), .co(right_r.carry)
    );

    shf_rrx_unit #(.W(DATA_W)) u_rrx (
        .val(op_val), .cin(carry_in), .res(rrx_r.data), .co(rrx_r.carry)
    );

    always_comb begin
        amt_zero = (shamt == '0);
        case (k)
            K_LSL:               sel_r = amt_zero ? mk_pass(op_val, carry_in) : left_r;
            K_LSR, K_ASR, K_ROR: sel_r = amt_zero ? mk_pass(op_val, carry_in) : right_r;
            K_RRX:               sel_r = rrx_r;
            default:             sel_r = mk_pass(op_val, carry_in);
        endcase
    end

    assign res       = sel_r.data;
    assign carry_out = sel_r.carry;

    always_comb begin
        if (k == K_LSL && !amt_zero)
            assert_lsl_low_zero_R1: assert (res[0] == 1'b0);
        if (k == K_LSR && !amt_zero)
            assert_lsr_top_zero_R2: assert (res[DATA_W-1] == 1'b0);
        if (k == K_ASR)
            assert_asr_sign_kept_R3: assert (res[DATA_W-1] == op_val[DATA_W-1]);
        if (k == K_ROR)
            assert_ror_popcount_R4: assert ($countones(res) == $countones(op_val));
        if (k == K_RRX)
            assert_rrx_carry_path_R5: assert (res[DATA_W-1] == carry_in && carry_out == op_val[0]);
        if (k inside {K_LSL, K_LSR, K_ASR, K_ROR} && amt_zero)
            assert_zero_amt_pass_R6: assert (res == op_val && carry_out == carry_in);
        if (k inside {K_RS5, K_RS6, K_RS7})
            assert_unused_pass_R7: assert (res == op_val && carry_out == carry_in);
    end
endmodule

// File: tb/sim_operand_shifter.sv
module sim_operand_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_val = '0;
    logic [4:0]  shamt = '0;
    logic [2:0]  kind = '0;
    logic        carry_in = 1'b0;
    logic [31:0] res;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    operand_shifter u0 (
        .op_val(op_val), .shamt(shamt), .kind(kind), .carry_in(carry_in),
        .res(res), .carry_out(carry_out)
    );

    task automatic chk32(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s kind=%0d n=%0d c=%0b in=%h: got %h expected %h",
                     req, kind, shamt, carry_in, op_val, got, exp);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s carry kind=%0d n=%0d c=%0b in=%h: got %0b expected %0b",
                     req, kind, shamt, carry_in, op_val, got, exp);
        end
    endtask

    function automatic string req_of(input int k, input int n);
        if (k >= 5) return "R7";
        if (k == 4) return "R5";
        if (n == 0) return "R6";
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [8];
        logic [31:0] exp_v;
        logic        exp_c;
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000;
        pats[3] = 32'h0000_0001;
        pats[4] = 32'hA5A5_5A5A;
        pats[5] = 32'h7F00_81FE;
        pats[6] = 32'h8000_0001;
        pats[7] = 32'h1234_ABCD;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // reset-time state: zero word, zero distance, op 0 -> zero word, carry 0 (R6)
        chk32("R6", res, 32'h0);
        chk1("R6", carry_out, 1'b0);

        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 32; n++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int p = 0; p < 8; p++) begin
                        @(negedge clk);
                        op_val   = pats[p];
                        shamt    = 5'(n);
                        kind     = 3'(k);
                        carry_in = c[0];
                        exp_v = pats[p];
                        exp_c = c[0];
                        if (k == 4) begin
                            // R5: carry-extended rotate, distance ignored
                            exp_v = {c[0], pats[p][31:1]};
                            exp_c = pats[p][0];
                        end else if (k < 4 && n != 0) begin
                            for (int i = 0; i < 32; i++) begin
                                case (k)
                                    0: exp_v[i] = (i >= n) ? pats[p][i-n] : 1'b0;
                                    1: exp_v[i] = (i + n < 32) ? pats[p][i+n] : 1'b0;
                                    2: exp_v[i] = (i + n < 32) ? pats[p][i+n] : pats[p][31];
                                    default: exp_v[i] = pats[p][(i+n)%32];
                                endcase
                            end
                            exp_c = (k == 0) ? pats[p][32-n] : pats[p][n-1];
                        end
                        #2;
                        chk32(req_of(k, n), res, exp_v);
                        chk1(req_of(k, n), carry_out, exp_c);
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule